// File: doc/BRIEF.md
# Sequential Six-Channel Word Demultiplexer

This block takes a stream of 10-bit words, one per active clock edge, and deals them out in turn into six first-stage channel registers. A start flag opens each group, and a direction input sets whether the group fills from channel 0 upward or from channel 5 downward. An edge-select input picks whether words are taken on rising or on falling clock edges. Once six words have landed, the block stops filling and raises a done flag. Any words that arrive after that are ignored until the next start.

A transfer strobe, sampled on a rising edge, copies all six first-stage words into a six-word output stage on the next falling edge. The output stage keeps its value while the following group fills, so downstream converters always see a complete and coherent set of six. A polarity bit travels with the output words and is captured on the same falling edge.

Top module: `chan_demux`

## Requirements
- R1: While `rst` is high at a clock edge, the output words, `inv_out` and `seq_done` are cleared to zero.
- R2: With `edge_rise`=1, words are taken on rising clock edges. With `dir_down`=0 the k-th word of a group (k=0..5) goes to channel k. With `dir_down`=1 it goes to channel 5-k.
- R3: With `edge_rise`=0, words are taken on falling clock edges, using the same channel order as R2.
- R4: A group starts on an active edge when `seq_start` was high at the previous active edge of the same polarity. The word present at that edge is the group's first word.
- R5: After six words, `seq_done` goes to 1 and the channel pointer holds. Further words change no channel until the next start. `seq_done` reads 0 after the fifth word.
- R6: A start that arrives during a group begins a fresh group from the first channel.
- R7: `edge_rise` and `dir_down` take effect only at a start. Changing either in mid-group leaves the group's edge and order unchanged.
- R8: When `xfer` is high at a rising edge, all six first-stage words appear on `dout` at the next falling edge. Channel c occupies bits [10c+9:10c].
- R9: Without a transfer, `dout` holds its value while a new group fills the first stage.
- R10: If a transfer and the last word of a falling-edge group share one falling edge, `dout` receives the first-stage values as they stood before that edge.
- R11: `inv_out` takes the value of `inv_in` at each transfer falling edge and holds it otherwise.
- R12: A transfer copies the first stage of the polarity selected by `edge_rise` at the rising edge where `xfer` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Data word, bit 9 is MSB |
| edge_rise | input | 1 | 1: rising-edge loading, 0: falling-edge loading |
| dir_down | input | 1 | 0: fill channel 0 upward, 1: fill channel 5 downward |
| seq_start | input | 1 | Start flag for a new group |
| xfer | input | 1 | Transfer strobe, sampled on rising edges |
| inv_in | input | 1 | Polarity bit, captured with each transfer |
| dout | output | 60 | Six output words, channel c at bits [10c+9:10c] |
| inv_out | output | 1 | Registered polarity bit |
| seq_done | output | 1 | Group of the selected polarity is complete |

## Verification
The bench uses a table that covers all four combinations of load edge and fill direction. Each combination runs with a distinct word ramp, so a wrong channel order, a wrong edge or a swapped bank shows up as a mismatched word position. Surplus words sent after each group separate a pointer that holds from one that wraps. A look at `dout` before each transfer separates a true double buffer from a transparent one. Directed cases then cover a restart in mid-group, a flip of edge and direction in mid-group, a transfer on the same edge as the last load, a transfer from the other polarity's bank, and polarity-bit capture.

// File: rtl/demux_pkg.sv
package demux_pkg;
    localparam int WORD_W = 10;
    localparam int NCH    = 6;
    localparam int PTR_W  = $clog2(NCH);
    localparam int CNT_W  = $clog2(NCH + 1);

    typedef logic [WORD_W-1:0]           word_t;
    typedef logic [PTR_W-1:0]            chan_t;
    typedef logic [NCH-1:0][WORD_W-1:0]  bank_t;

    typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } edge_e;
    typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 }     dir_e;

    typedef struct packed {
        logic              active;
        logic              done;
        dir_e              dir;
        chan_t             ptr;
        logic [CNT_W-1:0]  left;
    } seq_state_t;

    function automatic chan_t first_chan(dir_e d);
        return (d == DIR_DOWN) ? chan_t'(NCH - 1) : chan_t'(0);
    endfunction

    function automatic chan_t step_chan(chan_t p, dir_e d);
        if (d == DIR_DOWN)
            return (p == chan_t'(0)) ? p : p - chan_t'(1);
        else
            return (p == chan_t'(NCH - 1)) ? p : p + chan_t'(1);
    endfunction
endpackage

// File: rtl/seq_bank.sv
module seq_bank
    import demux_pkg::*;
#(
    parameter edge_e POL = EDGE_RISE
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t din,
    input  edge_e edge_sel,
    input  dir_e  dir_in,
    input  logic  start,
    output bank_t bank,
    output logic  done
);
    logic eclk;

    generate
        if (POL == EDGE_RISE) begin : g_rise
            assign eclk = clk;
        end else begin : g_fall
            assign eclk = ~clk;
        end
    endgenerate

    seq_state_t st, st_nxt;
    bank_t      bank_nxt;
    logic       start_q;
    logic       restart;
    chan_t      fch;

    assign restart = start_q && (edge_sel == POL);
    assign fch     = first_chan(dir_in);

    always_comb begin
        st_nxt   = st;
        bank_nxt = bank;
        if (restart) begin
            bank_nxt[fch] = din;
            st_nxt.dir    = dir_in;
            st_nxt.left   = CNT_W'(NCH - 1);
            st_nxt.active = (NCH > 1);
            st_nxt.done   = (NCH == 1);
            st_nxt.ptr    = step_chan(fch, dir_in);
        end else if (st.active) begin
            bank_nxt[st.ptr] = din;
            st_nxt.left      = st.left - CNT_W'(1);
            if (st.left == CNT_W'(1)) begin
                st_nxt.active = 1'b0;
                st_nxt.done   = 1'b1;
            end else begin
                st_nxt.ptr = step_chan(st.ptr, st.dir);
            end
        end
    end

    always_ff @(posedge eclk) begin
        if (rst) begin
            st      <= '0;
            bank    <= '0;
            start_q <= 1'b0;
        end else begin
            st      <= st_nxt;
            bank    <= bank_nxt;
            start_q <= start;
        end
    end

    assign done = st.done;

    // R5: a finished group ignores further words
    assert_hold_after_done_R5: assert property (@(posedge eclk) disable iff (rst)
        (st.done && !restart) |=> ($stable(bank) && done));

    // R4: first word of an upward group lands in channel 0
    assert_first_up_R4: assert property (@(posedge eclk) disable iff (rst)
        (restart && dir_in == DIR_UP) |=> (bank[0] == $past(din)));

    // R4: first word of a downward group lands in the last channel
    assert_first_down_R4: assert property (@(posedge eclk) disable iff (rst)
        (restart && dir_in == DIR_DOWN) |=> (bank[NCH-1] == $past(din)));

    // R6: a start clears the done flag
    assert_restart_clears_R6: assert property (@(posedge eclk) disable iff (rst)
        restart |=> !done);
endmodule

// File: rtl/xfer_stage.sv
module xfer_stage
    import demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  xfer,
    input  edge_e edge_sel,
    input  logic  inv_in,
    input  bank_t bank_r,
    input  bank_t bank_f,
    output bank_t dout,
    output logic  inv_out
);
    logic  xfer_q;
    edge_e pick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= 1'b0;
            pick_q <= EDGE_FALL;
        end else begin
            xfer_q <= xfer;
            pick_q <= edge_sel;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            dout    <= '0;
            inv_out <= 1'b0;
        end else if (xfer_q) begin
            dout    <= (pick_q == EDGE_RISE) ? bank_r : bank_f;
            inv_out <= inv_in;
        end
    end

    // R9: output stage holds without a transfer
    assert_hold_R9: assert property (@(negedge clk) disable iff (rst)
        !xfer_q |=> ($stable(dout) && $stable(inv_out)));

    // R8: transfer copies the rising-edge bank
    assert_copy_rise_R8: assert property (@(negedge clk) disable iff (rst)
        (xfer_q && pick_q == EDGE_RISE) |=> (dout == $past(bank_r)));

    // R10: transfer copies the falling-edge bank as it stood before the edge
    assert_copy_fall_R10: assert property (@(negedge clk) disable iff (rst)
        (xfer_q && pick_q == EDGE_FALL) |=> (dout == $past(bank_f)));

    // R11: polarity bit captured at the transfer edge
    assert_inv_R11: assert property (@(negedge clk) disable iff (rst)
        xfer_q |=> (inv_out == $past(inv_in)));
endmodule

// File: rtl/chan_demux.sv
module chan_demux
    import demux_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [WORD_W-1:0]       din,
    input  logic                    edge_rise,
    input  logic                    dir_down,
    input  logic                    seq_start,
    input  logic                    xfer,
    input  logic                    inv_in,
    output logic [NCH*WORD_W-1:0]   dout,
    output logic                    inv_out,
    output logic                    seq_done
);
    bank_t banks [2];
    logic  dones [2];
    bank_t dout_b;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_eng
            seq_bank #(.POL(edge_e'(g))) i_bank (
                .clk      (clk),
                .rst      (rst),
                .din      (din),
                .edge_sel (edge_e'(edge_rise)),
                .dir_in   (dir_e'(dir_down)),
                .start    (seq_start),
                .bank     (banks[g]),
                .done     (dones[g])
            );
        end
    endgenerate

    xfer_stage i_xfer (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .edge_sel (edge_e'(edge_rise)),
        .inv_in   (inv_in),
        .bank_r   (banks[1]),
        .bank_f   (banks[0]),
        .dout     (dout_b),
        .inv_out  (inv_out)
    );

    assign dout     = dout_b;
    assign seq_done = edge_rise ? dones[1] : dones[0];
endmodule

// File: tb/test_chan_demux.sv
module test_chan_demux;
    import demux_pkg::*;

    localparam int CLK_NS = 10;
    localparam int NV = 6;
    // [11] edge_rise, [10] dir_down, [9:0] first word of the ramp
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 1'b0, 10'h3FF}, {1'b0, 1'b1, 10'h155}, {1'b1, 1'b1, 10'h001},
        {1'b0, 1'b0, 10'h2AA}, {1'b1, 1'b0, 10'h000}, {1'b0, 1'b1, 10'h3F0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [WORD_W-1:0] din = '0;
    logic edge_rise = 1'b1, dir_down = 1'b0, seq_start = 1'b0, xfer = 1'b0, inv_in = 1'b0;
    logic [NCH*WORD_W-1:0] dout;
    logic inv_out, seq_done;

    int total = 0, bad = 0;
    bank_t mdl [2];
    bank_t shown;

    always #(CLK_NS/2) clk = ~clk;

    chan_demux i_chan_demux (
        .clk(clk), .rst(rst), .din(din), .edge_rise(edge_rise), .dir_down(dir_down),
        .seq_start(seq_start), .xfer(xfer), .inv_in(inv_in),
        .dout(dout), .inv_out(inv_out), .seq_done(seq_done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sync(input logic pol);
        if (pol) @(posedge clk); else @(negedge clk);
        #1;
    endtask

    function automatic word_t ramp(input word_t base, input int k);
        return word_t'(base + word_t'(k * 167));
    endfunction

    // flip: change edge/dir in mid-group; same_xfer: transfer on last load edge
    task automatic load_seq(input logic pol, input logic dir, input word_t base,
                            input bit flip, input bit same_xfer);
        sync(pol);
        edge_rise = pol; dir_down = dir;
        seq_start = 1'b1; din = ~base;
        sync(pol);
        seq_start = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            din = ramp(base, k);
            if (flip && k == 2) begin edge_rise = ~pol; dir_down = ~dir; end
            if (flip && k == 4) begin edge_rise = pol;  dir_down = dir;  end
            if (same_xfer && k == NCH-1) begin shown = mdl[pol]; xfer = 1'b1; end
            sync(pol);
            if (same_xfer && k == NCH-1) xfer = 1'b0;
            mdl[pol][dir ? NCH-1-k : k] = ramp(base, k);
            if (k == NCH-2) chk("R5 done low after fifth word", 64'(seq_done), 64'd0);
            if (k == NCH-1) chk("R5 done after sixth word", 64'(seq_done), 64'd1);
            if (same_xfer && k == NCH-1)
                chk("R10 same-edge transfer takes old values", 64'(dout), 64'(shown));
        end
        for (int j = 0; j < 2; j++) begin
            din = ~ramp(base, j);
            sync(pol);
        end
        chk("R5 done holds while extra words arrive", 64'(seq_done), 64'd1);
    endtask

    task automatic do_xfer;
        @(negedge clk); #1;
        xfer = 1'b1;
        @(posedge clk); #1;
        xfer = 1'b0;
        @(negedge clk); #1;
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mdl[0] = '0; mdl[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        chk("R1 reset dout", 64'(dout), 64'd0);
        chk("R1 reset inv_out", 64'(inv_out), 64'd0);
        chk("R1 reset seq_done", 64'(seq_done), 64'd0);

        // R2 R3 R4 R5 R8 R9 R12: table of edge/direction combinations
        shown = '0;
        for (int v = 0; v < NV; v++) begin
            load_seq(VEC[v][11], VEC[v][10], VEC[v][9:0], 1'b0, 1'b0);
            chk("R9 dout holds before transfer", 64'(dout), 64'(shown));
            do_xfer();
            chk(VEC[v][11] ? "R2 R8 rising-edge group transferred"
                           : "R3 R8 falling-edge group transferred",
                64'(dout), 64'(mdl[VEC[v][11]]));
            shown = mdl[VEC[v][11]];
        end

        // R6: restart in mid-group
        sync(1'b1);
        edge_rise = 1'b1; dir_down = 1'b0; seq_start = 1'b1;
        sync(1'b1); seq_start = 1'b0;
        for (int k = 0; k < 3; k++) begin din = 10'h0F0 + 10'(k); sync(1'b1); end
        chk("R6 group in progress not done", 64'(seq_done), 64'd0);
        load_seq(1'b1, 1'b1, 10'h123, 1'b0, 1'b0);
        do_xfer();
        chk("R6 restarted group fully replaces channels", 64'(dout), 64'(mdl[1]));

        // R7: edge/direction flip in mid-group ignored
        load_seq(1'b1, 1'b0, 10'h2C4, 1'b1, 1'b0);
        do_xfer();
        chk("R7 rising group unaffected by mid-group flip", 64'(dout), 64'(mdl[1]));
        load_seq(1'b0, 1'b1, 10'h07B, 1'b1, 1'b0);
        do_xfer();
        chk("R7 falling group unaffected by mid-group flip", 64'(dout), 64'(mdl[0]));

        // R10: transfer on the same falling edge as the last load
        load_seq(1'b0, 1'b0, 10'h3A1, 1'b0, 1'b1);
        do_xfer();
        chk("R10 following transfer shows full group", 64'(dout), 64'(mdl[0]));

        // R12: select the other polarity's first stage at transfer time
        edge_rise = 1'b1;
        do_xfer();
        chk("R12 transfer picks rising bank", 64'(dout), 64'(mdl[1]));
        edge_rise = 1'b0;
        do_xfer();
        chk("R12 transfer picks falling bank", 64'(dout), 64'(mdl[0]));

        // R11: polarity bit
        inv_in = 1'b1;
        do_xfer();
        chk("R11 inv_out captured high", 64'(inv_out), 64'd1);
        inv_in = 1'b0;
        @(negedge clk); #1;
        chk("R11 inv_out holds without transfer", 64'(inv_out), 64'd1);
        do_xfer();
        chk("R11 inv_out captured low", 64'(inv_out), 64'd0);

        // R1: reset after activity
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); @(negedge clk); #1 rst = 1'b0;
        chk("R1 reset clears dout", 64'(dout), 64'd0);
        chk("R1 reset clears seq_done", 64'(seq_done), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule